// File: doc/BRIEF.md
# Packet-Staging Receive FIFO Controller

This controller sits between two receive buffers. The first buffer is filled one character at a time by the link receiver. The second buffer is read by the host. Each first-stage word is nine bits wide: eight data bits plus a marker bit. A word with the marker bit clear is a normal data character. A word with the marker bit set closes a packet. If its data field is all zero, the packet ended normally. Any other data field means the packet ended with an error.

The controller copies data characters into the second buffer until it pops a packet terminator. It then stops forwarding and raises a flag that tells the host which kind of ending arrived. The flag stays up, and forwarding stays frozen, until the host has emptied the second buffer. The host therefore only ever sees one whole packet at a time. Forwarding also pauses while the second buffer has no free entry, and it resumes without losing any character.

A synchronous link-disable input clears both flags and puts the controller back into forwarding, exactly as reset does. The controller also offers a registered copy of the second buffer's fill count as a status value.

Top module: `rx_pkt_stager`

## Requirements
- R1: After reset, `gotEop`, `gotEep`, `f2WrEn` and `heldCount` are all 0, and the controller is forwarding.
- R2: A first-stage word with bit 8 = 0 that is popped (`f1RdEn` high) appears on `f2Data` with `f2WrEn` high in the next cycle. Characters reach the second buffer in arrival order.
- R3: A first-stage word with bit 8 = 1 is popped but never written to the second buffer.
- R4: Popping a marker word with data 8'h00 sets `gotEop` in the next cycle. Popping a marker word with any non-zero data sets `gotEep` instead. The two flags are never high together.
- R5: While either flag is high, `f1RdEn` stays 0, whatever the first buffer holds.
- R6: While a flag is high, it is cleared (and forwarding resumes) in the cycle after one in which `f2Count` is 0 and `f2WrEn` is 0. A terminator that arrives with the second buffer already empty therefore raises its flag for exactly one cycle.
- R7: A data word is not popped while `f2Count` plus an in-flight write reaches `F2_DEPTH`. The second buffer never overflows, and no character is lost or reordered across the stall.
- R8: `heldCount` equals the value `f2Count` had one cycle earlier.
- R9: `linkOff` blocks popping in the cycle it is high and clears both flags in the next cycle. Forwarding then resumes even if the second buffer still holds data.
- R10: `f1RdEn` is never high while `f1Empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| linkOff | input | 1 | Link disabled; synchronous clear of the flags and the state |
| f1Word | input | DATA_W+1 | First-stage head word; the top bit is the marker |
| f1Empty | input | 1 | First-stage buffer empty |
| f1RdEn | output | 1 | Pop the first-stage head word (show-ahead read) |
| f2Data | output | DATA_W | Data character written into the second-stage buffer |
| f2WrEn | output | 1 | Write strobe for the second-stage buffer |
| f2Count | input | CNT_W | Fill count of the second-stage buffer |
| heldCount | output | CNT_W | Registered fill count for host status |
| gotEop | output | 1 | Packet held; it ended normally |
| gotEep | output | 1 | Packet held; it ended with an error |

## Verification
The pop strobe is combinational in the cycle the head word is presented. The resulting write, the flag set, the flag clear and the status count each land exactly one register later. The bench models both buffers so that their contents change 1 ns after a rising edge, and it samples every output at the falling edge. For each timed requirement it first finds the falling edge where the cause is visible (a marker pop, or a zero count). It then checks the effect at that same edge or the next one, matching the single register stage. The stall case is checked after the pipeline settles, by comparing the final count, the leftover first-stage words and the full drained byte sequence.

// File: rtl/rx_pkt_stager_pkg.sv
package rx_pkt_stager_pkg;

  typedef enum logic {
    ST_FWD  = 1'b0,
    ST_HOLD = 1'b1
  } stageState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic setEop;
    logic setEep;
    logic clearMarks;
  } stageStrobe_t;

  // decoded conditions from datapath to control
  typedef struct packed {
    logic wordValid;
    logic isMarker;
    logic isEopCode;
    logic hasRoom;
    logic drained;
  } stageView_t;

endpackage

// File: rtl/rx_pkt_stager_dp.sv
module rx_pkt_stager_dp
  import rx_pkt_stager_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int F2_DEPTH = 64,
  parameter int CNT_W    = $clog2(F2_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W:0]   f1Word,
  input  logic              f1Empty,
  input  logic [CNT_W-1:0]  f2Count,
  input  stageStrobe_t      strb,
  output stageView_t        view,
  output logic [DATA_W-1:0] f2Data,
  output logic              f2WrEn,
  output logic [CNT_W-1:0]  heldCount,
  output logic              gotEop,
  output logic              gotEep
);

  localparam int OCC_W = CNT_W + 1;
  localparam logic [OCC_W-1:0] DEPTH_LIM = OCC_W'(F2_DEPTH);

  logic [OCC_W-1:0] occupied;

  // a write still in flight is not yet visible in the fill count
  always_comb begin
    occupied       = {1'b0, f2Count} + OCC_W'(f2WrEn);
    view.wordValid = !f1Empty;
    view.isMarker  = f1Word[DATA_W];
    view.isEopCode = (f1Word[DATA_W-1:0] == '0);
    view.hasRoom   = (occupied < DEPTH_LIM);
    view.drained   = (f2Count == '0) && !f2WrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      f2WrEn    <= 1'b0;
      f2Data    <= '0;
      heldCount <= '0;
    end else begin
      f2WrEn    <= strb.load;
      heldCount <= f2Count;
      if (strb.load) f2Data <= f1Word[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gotEop <= 1'b0;
      gotEep <= 1'b0;
    end else if (strb.clearMarks) begin
      gotEop <= 1'b0;
      gotEep <= 1'b0;
    end else if (strb.setEop) begin
      gotEop <= 1'b1;
    end else if (strb.setEep) begin
      gotEep <= 1'b1;
    end
  end

endmodule

// File: rtl/rx_pkt_stager_ctrl.sv
module rx_pkt_stager_ctrl
  import rx_pkt_stager_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         linkOff,
  input  stageView_t   view,
  output stageStrobe_t strb,
  output logic         f1RdEn
);

  stageState_t state, stateNext;
  logic popNow;

  always_comb begin
    popNow = (state == ST_FWD) && !linkOff && view.wordValid &&
             (view.isMarker || view.hasRoom);
    strb.load       = popNow && !view.isMarker;
    strb.setEop     = popNow && view.isMarker && view.isEopCode;
    strb.setEep     = popNow && view.isMarker && !view.isEopCode;
    strb.clearMarks = linkOff || ((state == ST_HOLD) && view.drained);

    stateNext = state;
    unique case (state)
      ST_FWD:  if (strb.setEop || strb.setEep) stateNext = ST_HOLD;
      ST_HOLD: if (strb.clearMarks) stateNext = ST_FWD;
      default: stateNext = ST_FWD;
    endcase
    if (linkOff) stateNext = ST_FWD;
  end

  assign f1RdEn = popNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FWD;
    else       state <= stateNext;
  end

endmodule

// File: rtl/rx_pkt_stager.sv
module rx_pkt_stager
  import rx_pkt_stager_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int F2_DEPTH = 64,
  parameter int CNT_W    = $clog2(F2_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkOff,
  input  logic [DATA_W:0]   f1Word,
  input  logic              f1Empty,
  output logic              f1RdEn,
  output logic [DATA_W-1:0] f2Data,
  output logic              f2WrEn,
  input  logic [CNT_W-1:0]  f2Count,
  output logic [CNT_W-1:0]  heldCount,
  output logic              gotEop,
  output logic              gotEep
);

  stageStrobe_t strb;
  stageView_t   view;

  rx_pkt_stager_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .linkOff (linkOff),
    .view    (view),
    .strb    (strb),
    .f1RdEn  (f1RdEn)
  );

  rx_pkt_stager_dp #(
    .DATA_W   (DATA_W),
    .F2_DEPTH (F2_DEPTH),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .f1Word    (f1Word),
    .f1Empty   (f1Empty),
    .f2Count   (f2Count),
    .strb      (strb),
    .view      (view),
    .f2Data    (f2Data),
    .f2WrEn    (f2WrEn),
    .heldCount (heldCount),
    .gotEop    (gotEop),
    .gotEep    (gotEep)
  );

endmodule

// File: rtl/rx_pkt_stager_chk.sv
module rx_pkt_stager_chk #(
  parameter int DATA_W   = 8,
  parameter int F2_DEPTH = 64,
  parameter int CNT_W    = $clog2(F2_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              linkOff,
  input logic [DATA_W:0]   f1Word,
  input logic              f1Empty,
  input logic              f1RdEn,
  input logic [DATA_W-1:0] f2Data,
  input logic              f2WrEn,
  input logic [CNT_W-1:0]  f2Count,
  input logic [CNT_W-1:0]  heldCount,
  input logic              gotEop,
  input logic              gotEep
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(F2_DEPTH);

  AST_RD_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    f1RdEn |-> !f1Empty); // R10

  AST_DATA_FORWARDED: assert property (@(posedge clk) disable iff (!rstN)
    (f1RdEn && !f1Word[DATA_W]) |=> (f2WrEn && f2Data == $past(f1Word[DATA_W-1:0]))); // R2

  AST_MARKER_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (f1RdEn && f1Word[DATA_W]) |=> !f2WrEn); // R3

  AST_EOP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (f1RdEn && f1Word[DATA_W] && f1Word[DATA_W-1:0] == '0) |=> (gotEop && !gotEep)); // R4

  AST_EEP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (f1RdEn && f1Word[DATA_W] && f1Word[DATA_W-1:0] != '0) |=> (gotEep && !gotEop)); // R4

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(gotEop && gotEep)); // R4

  AST_HOLD_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    (gotEop || gotEep) |-> !f1RdEn); // R5

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ((gotEop || gotEep) && f2Count == '0 && !f2WrEn) |=> (!gotEop && !gotEep)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    f2WrEn |-> (f2Count < FULL_CNT)); // R7

  AST_COUNT_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (heldCount == $past(f2Count))); // R8

  AST_LINK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    linkOff |-> (!f1RdEn ##1 (!gotEop && !gotEep && !f2WrEn))); // R9

endmodule

bind rx_pkt_stager rx_pkt_stager_chk #(
  .DATA_W   (DATA_W),
  .F2_DEPTH (F2_DEPTH),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .linkOff   (linkOff),
  .f1Word    (f1Word),
  .f1Empty   (f1Empty),
  .f1RdEn    (f1RdEn),
  .f2Data    (f2Data),
  .f2WrEn    (f2WrEn),
  .f2Count   (f2Count),
  .heldCount (heldCount),
  .gotEop    (gotEop),
  .gotEep    (gotEep)
);

// File: tb/test_rx_pkt_stager.sv
`timescale 1ns/1ps
module test_rx_pkt_stager;

  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic linkOff = 1'b0;
  logic [DW:0] f1Word = '0;
  logic f1Empty = 1'b1;
  logic f1RdEn;
  logic [DW-1:0] f2Data;
  logic f2WrEn;
  logic [CW-1:0] f2Count = '0;
  logic [CW-1:0] heldCount;
  logic gotEop, gotEep;

  always #5 clk = ~clk;

  rx_pkt_stager #(.DATA_W(DW), .F2_DEPTH(DEPTH)) i_rx_pkt_stager (
    .clk(clk), .rstN(rstN), .linkOff(linkOff), .f1Word(f1Word), .f1Empty(f1Empty),
    .f1RdEn(f1RdEn), .f2Data(f2Data), .f2WrEn(f2WrEn), .f2Count(f2Count),
    .heldCount(heldCount), .gotEop(gotEop), .gotEep(gotEep)
  );

  // buffer models
  logic [DW:0]   f1Q[$];
  logic [DW-1:0] f2Q[$];
  logic [DW-1:0] rxQ[$];
  logic hostRd = 1'b0;
  logic sPop, sPush, sRd;
  logic [DW-1:0] sData;
  int ovfCnt = 0, mirrorErr = 0, checkCnt = 0, failCnt = 0;
  logic [CW-1:0] prevCount = '0;
  logic prevValid = 1'b0;
  logic done = 1'b0;

  function automatic void refresh();
    f1Empty = (f1Q.size() == 0);
    f1Word  = (f1Q.size() > 0) ? f1Q[0] : '0;
    f2Count = CW'(f2Q.size());
  endfunction

  always @(negedge clk) begin
    sPop  = f1RdEn;
    sPush = f2WrEn;
    sData = f2Data;
    sRd   = hostRd && (f2Q.size() > 0);
    if (prevValid && heldCount != prevCount) mirrorErr++;
    prevCount = f2Count;
    prevValid = rstN;
  end

  always @(posedge clk) begin
    #1;
    if (sPop && f1Q.size() > 0) void'(f1Q.pop_front());
    if (sPush) begin
      if (f2Q.size() >= DEPTH) ovfCnt++;
      f2Q.push_back(sData);
    end
    if (sRd) rxQ.push_back(f2Q.pop_front());
    refresh();
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushWord(input logic [DW:0] w);
    @(posedge clk); #2;
    f1Q.push_back(w);
    refresh();
  endtask

  task automatic setHost(input logic v);
    @(posedge clk); #2;
    hostRd = v;
  endtask

  // wait for a marker pop, then check the flag one edge later
  task automatic waitMarker(input bit expEop, input string req);
    bit seen = 0;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      if (f1RdEn && f1Word[DW]) seen = 1;
    end
    @(negedge clk);
    check(seen && gotEop == expEop && gotEep == !expEop, req, {gotEop, gotEep}, expEop ? 2 : 1);
  endtask

  task automatic drainAll();
    setHost(1'b1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (f2Count == 0 && !gotEop && !gotEep) break;
    end
    setHost(1'b0);
  endtask

  task automatic tReset();
    @(negedge clk);
    check(!gotEop && !gotEep && !f2WrEn && heldCount == 0, "R1 reset state",
          {gotEop, gotEep, f2WrEn}, 0);
    check(!f1RdEn, "R10 no pop when empty", f1RdEn, 0);
  endtask

  task automatic tEopPacket();
    rxQ.delete();
    pushWord(9'h0A1); pushWord(9'h0A2); pushWord(9'h0A3); pushWord(9'h100);
    waitMarker(1'b1, "R4 EOP flag");
    check(f2Count == 3, "R3 marker not stored", f2Count, 3);
    pushWord(9'h0B1);
    repeat (5) @(negedge clk);
    check(f1Q.size() == 1, "R5 frozen while held", f1Q.size(), 1);
    check(gotEop, "R6 flag held while data stored", gotEop, 1);
    check(heldCount == 3, "R8 status count", heldCount, 3);
    setHost(1'b1);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (f2Count == 0) break;
    end
    check(gotEop, "R6 flag still set at zero count", gotEop, 1);
    @(negedge clk);
    check(!gotEop, "R6 flag cleared one cycle after drain", gotEop, 0);
    hostRd = 1'b0;
    check(rxQ.size() == 3 && rxQ[0] == 8'hA1 && rxQ[1] == 8'hA2 && rxQ[2] == 8'hA3,
          "R2 packet order", rxQ.size(), 3);
  endtask

  task automatic tEepPacket();
    rxQ.delete();
    pushWord(9'h0B2); pushWord(9'h1A5);
    waitMarker(1'b0, "R4 EEP flag");
    drainAll();
    check(rxQ.size() == 2 && rxQ[0] == 8'hB1 && rxQ[1] == 8'hB2, "R2 EEP packet data",
          rxQ.size(), 2);
  endtask

  task automatic tFullStall();
    rxQ.delete();
    for (int i = 0; i < DEPTH + 3; i++) pushWord(9'(8'h40 + i));
    pushWord(9'h100);
    repeat (30) @(negedge clk);
    check(f2Count == DEPTH, "R7 filled to depth", f2Count, DEPTH);
    check(f1Q.size() == 4 && !gotEop, "R7 stalled words kept", f1Q.size(), 4);
    check(ovfCnt == 0, "R7 no overflow", ovfCnt, 0);
    setHost(1'b1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (gotEop) break;
    end
    check(gotEop, "R4 EOP after stall", gotEop, 1);
    drainAll();
    begin
      bit ok = (rxQ.size() == DEPTH + 3);
      for (int i = 0; i < rxQ.size() && ok; i++) if (rxQ[i] != 8'(8'h40 + i)) ok = 0;
      check(ok, "R7 no loss across stall", rxQ.size(), DEPTH + 3);
    end
  endtask

  task automatic tLinkOff();
    pushWord(9'h0C1); pushWord(9'h100);
    waitMarker(1'b1, "R4 EOP before link off");
    pushWord(9'h0D1);
    @(posedge clk); #2; linkOff = 1'b1;
    @(negedge clk);
    check(!f1RdEn, "R9 no pop during link off", f1RdEn, 0);
    @(posedge clk); #2; linkOff = 1'b0;
    @(negedge clk);
    check(!gotEop && !gotEep, "R9 flags cleared", {gotEop, gotEep}, 0);
    repeat (4) @(negedge clk);
    check(f2Count == 2, "R9 forwarding resumed", f2Count, 2);
    pushWord(9'h100);
    waitMarker(1'b1, "R4 EOP after link off");
    drainAll();
  endtask

  task automatic tEmptyPacket();
    int high = 0;
    pushWord(9'h100);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (gotEop) high++;
    end
    check(high == 1, "R6 empty packet one-cycle flag", high, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    tReset();
    tEopPacket();
    tEepPacket();
    tFullStall();
    tLinkOff();
    tEmptyPacket();
    check(mirrorErr == 0, "R8 count mirror", mirrorErr, 0);
    check(ovfCnt == 0, "R7 overflow total", ovfCnt, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule